// File: doc/BRIEF.md
# Operand Bypass Selector

This block decides, for the instruction sitting in the execute stage of a five-stage in-order integer pipeline, where each of its two source operands should come from. There are three candidates: the value read from the register file during decode, the result held in the memory stage, or the result held in write-back. The block compares the two source indices of the execute instruction against the destination indices of the two older instructions. It produces one 2-bit select per operand. A select is produced for every operand field, whether or not the instruction reads that field. An instruction with no source fields, such as an unconditional jump, is still given the selects that its index bits imply.

The block also raises a stall request when the instruction one stage ahead is a load and its result is needed in the execute stage in the same cycle. A load result is not ready until the end of the memory stage. The request takes the meaning of the execute instruction into account. A store needs its data operand only when it reaches the memory stage. By then the loaded value can be taken from write-back, so a match on a store's data operand alone does not stall.

The selects and the stall flag are registered, with a synchronous active-high reset. They appear one clock after the stage snapshot is sampled. The pipeline presents the snapshot one cycle ahead, so the selects line up with the operand muxes.

Top module: `fwd_unit`

## Requirements
- R1: While reset is high at a clock edge, both selects and the stall flag are 0 after that edge. Select encoding: 2'b00 = register file, 2'b01 = memory stage, 2'b10 = write-back; 2'b11 is never produced.
- R2: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge and hold steady between edges.
- R3: If the memory-stage destination equals an operand's source index, with its write enable high and the index non-zero, that operand's select is 2'b01.
- R4: If only the write-back destination matches an operand (write enable high, index non-zero), that operand's select is 2'b10.
- R5: When both older stages match the same operand, the memory stage wins (2'b01), as it holds the newer value.
- R6: A destination index of 0 never produces a match and never a stall.
- R7: A stage whose write enable is low is never a bypass source and never causes a stall, even if its destination index matches.
- R8: The two operands are selected independently, and the store flag of the execute instruction has no effect on either select.
- R9: The stall flag is 1 when the memory stage holds a load (load flag and write enable high, non-zero destination) whose destination equals the execute instruction's first source index.
- R10: A load match on the second source index stalls only when the execute instruction is not a store (store flag 0).
- R11: Only a load in the memory stage can stall: a write-back match or a non-load memory-stage match leaves the stall flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_src_a | input | 5 | First source index of the execute instruction |
| ex_src_b | input | 5 | Second source index of the execute instruction |
| ex_is_store | input | 1 | Execute instruction is a store (second source is store data) |
| mem_dst | input | 5 | Destination index of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction takes its result from memory |
| wb_dst | input | 5 | Destination index of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| load_stall | output | 1 | Load-use stall request |

## Verification
Stage snapshots are chosen so that each test tells one decision apart from the others. Some snapshots match only the memory stage or only write-back, and some match both, which isolates the priority. Some carry a matching index with the write enable low or with index 0, which isolates the qualifiers. Load snapshots are tried against the first source, against the second source with and without the store flag, and against write-back, which separates the stall rule from the bypass rule. Directed tests also show that the outputs hold between edges and are cleared by reset.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEM     = 2'b01,
    SRC_WB      = 2'b10
  } fwd_src_e;

  localparam int unsigned OPERANDS = 2;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic             wb_wen,
  output fwd_src_e         sel,
  output logic             mem_hit
);
  logic wb_hit;

  // A zero destination never qualifies: register 0 always reads as zero.
  always_comb begin
    mem_hit = mem_wen && (mem_dst != '0) && (mem_dst == src_idx);
    wb_hit  = wb_wen  && (wb_dst  != '0) && (wb_dst  == src_idx);
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_REGFILE;
  end
endmodule

// File: rtl/fwd_hazard.sv
module fwd_hazard
  import fwd_pkg::*;
(
  input  logic [OPERANDS-1:0] mem_hit,
  input  logic                mem_is_load,
  input  logic                ex_is_store,
  output logic                stall
);
  // A store's data operand is consumed a stage later, when the load
  // result can already be taken from write-back.
  always_comb begin
    stall = mem_is_load && (mem_hit[0] || (mem_hit[1] && !ex_is_store));
  end
endmodule

// File: rtl/fwd_outreg.sv
module fwd_outreg #(
  parameter int unsigned W       = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ex_src_a,
  input  logic [IDX_W-1:0] ex_src_b,
  input  logic             ex_is_store,
  input  logic [IDX_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_is_load,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             load_stall
);
  localparam int unsigned SEL_W = $bits(fwd_src_e);
  localparam int unsigned OUT_W = OPERANDS * SEL_W + 1;

  logic [IDX_W-1:0]    src_idx [OPERANDS];
  fwd_src_e            sel_c   [OPERANDS];
  logic [OPERANDS-1:0] hit_c;
  logic                stall_c;
  logic [OUT_W-1:0]    out_d, out_q;

  assign src_idx[0] = ex_src_a;
  assign src_idx[1] = ex_src_b;

  generate
    for (genvar i = 0; i < OPERANDS; i++) begin : g_op
      fwd_select #(.IDX_W(IDX_W)) u_sel (
        .src_idx (src_idx[i]),
        .mem_dst (mem_dst),
        .mem_wen (mem_wen),
        .wb_dst  (wb_dst),
        .wb_wen  (wb_wen),
        .sel     (sel_c[i]),
        .mem_hit (hit_c[i])
      );
    end
  endgenerate

  fwd_hazard u_haz (
    .mem_hit     (hit_c),
    .mem_is_load (mem_is_load),
    .ex_is_store (ex_is_store),
    .stall       (stall_c)
  );

  assign out_d = {sel_c[1], sel_c[0], stall_c};

  fwd_outreg #(.W(OUT_W), .REG_OUT(REG_OUT)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign sel_b      = out_q[OUT_W-1 -: SEL_W];
  assign sel_a      = out_q[SEL_W -: SEL_W];
  assign load_stall = out_q[0];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] ex_src_a,
  input logic [IDX_W-1:0] ex_src_b,
  input logic             ex_is_store,
  input logic [IDX_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic             mem_is_load,
  input logic [IDX_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             load_stall
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !load_stall));
  a_r1_no_code3: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11 && sel_b != 2'b11));
  // R3, R5
  a_r3_mem_first: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mem_wen && mem_dst != 0 && mem_dst == ex_src_a))
      |-> sel_a == 2'b01);
  // R4
  a_r4_wb_only: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!(mem_wen && mem_dst == ex_src_b) &&
                          wb_wen && wb_dst != 0 && wb_dst == ex_src_b))
      |-> sel_b == 2'b10);
  // R6
  a_r6_zero_dst: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mem_dst == 0 && wb_dst == 0))
      |-> (sel_a == 2'b00 && sel_b == 2'b00 && !load_stall));
  // R7
  a_r7_no_wen: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!mem_wen && !wb_wen))
      |-> (sel_a == 2'b00 && sel_b == 2'b00 && !load_stall));
  // R9
  a_r9_load_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mem_is_load && mem_wen && mem_dst != 0 && mem_dst == ex_src_a))
      |-> load_stall);
  // R10
  a_r10_store_data: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ex_is_store && mem_dst != ex_src_a))
      |-> !load_stall);
  // R11
  a_r11_only_mem_load: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!(mem_is_load && mem_wen)))
      |-> !load_stall);
endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ex_src_a    (ex_src_a),
  .ex_src_b    (ex_src_b),
  .ex_is_store (ex_is_store),
  .mem_dst     (mem_dst),
  .mem_wen     (mem_wen),
  .mem_is_load (mem_is_load),
  .wb_dst      (wb_dst),
  .wb_wen      (wb_wen),
  .sel_a       (sel_a),
  .sel_b       (sel_b),
  .load_stall  (load_stall)
);

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
  typedef struct packed {
    logic [4:0]  ra, rb;
    logic        st;
    logic [4:0]  md;
    logic        mw, ml;
    logic [4:0]  wd;
    logic        ww;
    logic [1:0]  ea, eb;
    logic        es;
    int unsigned req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  1'b0, 5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 2'b01, 2'b00, 1'b0, 3},  // R3
    '{5'd3,  5'd4,  1'b0, 5'd4,  1'b1, 1'b0, 5'd9,  1'b1, 2'b00, 2'b01, 1'b0, 3},  // R3
    '{5'd7,  5'd8,  1'b0, 5'd1,  1'b1, 1'b0, 5'd7,  1'b1, 2'b10, 2'b00, 1'b0, 4},  // R4
    '{5'd7,  5'd8,  1'b0, 5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 2'b00, 2'b10, 1'b0, 4},  // R4
    '{5'd5,  5'd5,  1'b0, 5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 2'b01, 2'b01, 1'b0, 5},  // R5
    '{5'd31, 5'd31, 1'b0, 5'd31, 1'b1, 1'b0, 5'd31, 1'b1, 2'b01, 2'b01, 1'b0, 5},  // R5
    '{5'd0,  5'd0,  1'b0, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 1'b0, 6},  // R6
    '{5'd6,  5'd2,  1'b0, 5'd6,  1'b0, 1'b0, 5'd2,  1'b0, 2'b00, 2'b00, 1'b0, 7},  // R7
    '{5'd6,  5'd2,  1'b0, 5'd6,  1'b0, 1'b1, 5'd6,  1'b1, 2'b10, 2'b00, 1'b0, 7},  // R7
    '{5'd10, 5'd11, 1'b0, 5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 2'b01, 2'b00, 1'b1, 9},  // R9
    '{5'd12, 5'd13, 1'b0, 5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 2'b00, 2'b01, 1'b1, 10}, // R10
    '{5'd12, 5'd13, 1'b1, 5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 2'b00, 2'b01, 1'b0, 10}, // R10
    '{5'd13, 5'd12, 1'b1, 5'd13, 1'b1, 1'b1, 5'd0,  1'b0, 2'b01, 2'b00, 1'b1, 10}, // R10
    '{5'd14, 5'd15, 1'b0, 5'd1,  1'b1, 1'b0, 5'd14, 1'b1, 2'b10, 2'b00, 1'b0, 11}, // R11
    '{5'd20, 5'd21, 1'b1, 5'd21, 1'b1, 1'b0, 5'd20, 1'b1, 2'b10, 2'b01, 1'b0, 8}   // R8
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
  logic       ex_is_store = 1'b0, mem_wen = 1'b0, mem_is_load = 1'b0, wb_wen = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic       load_stall;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fwd_unit u_dut (
    .clk(clk), .rst(rst),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_is_store(ex_is_store),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .sel_a(sel_a), .sel_b(sel_b), .load_stall(load_stall)
  );

  task automatic check(input int unsigned req, input string what,
                       input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ex_src_a = v.ra; ex_src_b = v.rb; ex_is_store = v.st;
    mem_dst = v.md; mem_wen = v.mw; mem_is_load = v.ml;
    wb_dst = v.wd; wb_wen = v.ww;
  endtask

  task automatic check_all(input vec_t v, input int unsigned req);
    check(req, "sel_a", sel_a, v.ea);
    check(req, "sel_b", sel_b, v.eb);
    check(req, "stall", {1'b0, load_stall}, {1'b0, v.es});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state after release
    check(1, "reset sel_a", sel_a, 2'b00);
    check(1, "reset sel_b", sel_b, 2'b00);
    check(1, "reset stall", {1'b0, load_stall}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check_all(VECS[i], VECS[i].req);
    end

    // R2: new inputs do not show before the next rising edge
    @(negedge clk);
    drive(VECS[9]);
    @(negedge clk);
    drive(VECS[0]);
    #1;
    check(2, "hold sel_a", sel_a, 2'b01);
    check(2, "hold stall", {1'b0, load_stall}, 2'b01);
    @(negedge clk);
    check(2, "update stall", {1'b0, load_stall}, 2'b00);

    // R1: reset clears a live result
    drive(VECS[4]);
    @(negedge clk);
    check(1, "pre-reset sel_a", sel_a, 2'b01);
    rst = 1'b1;
    @(negedge clk);
    check(1, "in-reset sel_a", sel_a, 2'b00);
    check(1, "in-reset sel_b", sel_b, 2'b00);
    rst = 1'b0;
    @(negedge clk);
    check(1, "post-reset sel_b", sel_b, 2'b01);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule